// File: doc/BRIEF.md
# Multi-Port Shared Memory Controller

This block sits between several requesting processor ports and one large, slow backing memory. It decides which port is served next and answers reads from a small on-chip line store that acts as a direct-mapped cache. Read misses and all writes leave over a separate backing channel whose request and response are handshaked, so memories of any latency can be attached.

Each port raises a request with a direction bit, a 24-bit word address and, for writes, a 256-bit word. It holds these steady until a one-cycle grant pulse arrives. Read data for that port is valid on the port's own 256-bit lane during the grant cycle. A 24-bit word address names one 256-bit word, and that word is also the cache line.

Only one backing operation is outstanding at a time. While it is pending, read hits from the other ports are still served.

Top module: `mcu_shared_ctrl`

## Requirements
- R1: After reset every line is invalid, all grants are low and the backing request valid is low; the first read of any address therefore goes out on the backing channel.
- R2: Ports are chosen round-robin. The search starts at the port after the last accepted one, in rising port number, and wraps from port N-1 to port 0. At most one port is accepted per cycle.
- R3: A read hit is granted in the cycle after it is accepted, with the stored word, and issues no backing request.
- R4: On a read miss, a backing read is issued with the port's address. Valid, address and direction stay stable until ready is high. When the response arrives, the line is filled and the port is granted with the response word.
- R5: Every write is written through: a backing write carries the port's address and data, and the port is granted only when the backing response arrives.
- R6: A write whose address is cached updates the stored line. A write to an uncached address does not allocate, so the next read of that address misses.
- R7: The line index is the low 4 address bits and the tag is the remaining 20 bits. Two addresses with the same index replace each other.
- R8: While a backing operation is pending, read hits from other ports are still accepted and granted. At most two grants occur in one cycle: one hit and one backing completion.
- R9: A grant is a single-cycle pulse and goes only to a port that was requesting in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prt_req | input | 8 | Request per port, held until granted |
| prt_we | input | 8 | 1 = write, 0 = read, per port |
| prt_addr | input | 192 | 24-bit word address per port, port p at bits p*24 |
| prt_wdata | input | 2048 | 256-bit write word per port, port p at bits p*256 |
| prt_gnt | output | 8 | One-cycle grant pulse per port |
| prt_rdata | output | 2048 | 256-bit read lane per port, valid with its grant |
| bk_valid | output | 1 | Backing request valid |
| bk_ready | input | 1 | Backing request accepted |
| bk_we | output | 1 | Backing request is a write |
| bk_addr | output | 24 | Backing word address |
| bk_wdata | output | 256 | Backing write word |
| bk_rsp_valid | input | 1 | Backing response (read data or write done) |
| bk_rsp_data | input | 256 | Backing read word |

## Verification
On every cycle the assertions check the local handshake rules. Grants are single pulses and go only to ports that were requesting. No more than two grants occur at once. A backing request stays stable while ready is low. Only the directed scenarios can show the data results: round-robin order, the hit and miss latencies, write-through with no allocation, eviction on an index conflict, and a hit granted while a miss is still waiting.

// File: rtl/mcu_pkg.sv
package mcu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BK_REQ  = 2'd1,
        ST_BK_WAIT = 2'd2
    } mcu_state_e;
endpackage

// File: rtl/mcu_rr_pick.sv
module mcu_rr_pick #(
    parameter int N  = 8,
    parameter int PW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic [PW-1:0] pick,
    output logic          any
);
    always_comb begin
        pick = '0;
        any  = 1'b0;
        for (int off = 0; off < N; off++) begin
            int c;
            c = int'(ptr) + off;
            if (c >= N) c = c - N;
            if (!any && req[c]) begin
                any  = 1'b1;
                pick = PW'(c);
            end
        end
    end
endmodule

// File: rtl/mcu_line_store.sv
module mcu_line_store #(
    parameter int N_LK   = 9,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 256,
    parameter int IDX_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [N_LK*ADDR_W-1:0]   lk_addr,
    output logic [N_LK-1:0]          lk_hit,
    output logic [N_LK*DATA_W-1:0]   lk_data
);
    localparam int LINES = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [DATA_W-1:0] data_q [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINES-1:0]  vld_q;

    logic [IDX_W-1:0] wr_idx;
    assign wr_idx = wr_addr[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else if (wr_en) vld_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_idx] <= wr_data;
            tag_q[wr_idx]  <= wr_addr[ADDR_W-1:IDX_W];
        end
    end

    for (genvar g = 0; g < N_LK; g++) begin : g_lk
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
        assign idx = lk_addr[g*ADDR_W +: IDX_W];
        assign tag = lk_addr[g*ADDR_W+IDX_W +: TAG_W];
        assign lk_hit[g] = vld_q[idx] && (tag_q[idx] == tag);
        assign lk_data[g*DATA_W +: DATA_W] = data_q[idx];
    end

    // a line just written must hit on the next cycle at the same address
    p_fill_hits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/mcu_shared_ctrl.sv
module mcu_shared_ctrl #(
    parameter int N      = 8,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 256,
    parameter int IDX_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         prt_req,
    input  logic [N-1:0]         prt_we,
    input  logic [N*ADDR_W-1:0]  prt_addr,
    input  logic [N*DATA_W-1:0]  prt_wdata,
    output logic [N-1:0]         prt_gnt,
    output logic [N*DATA_W-1:0]  prt_rdata,
    output logic                 bk_valid,
    input  logic                 bk_ready,
    output logic                 bk_we,
    output logic [ADDR_W-1:0]    bk_addr,
    output logic [DATA_W-1:0]    bk_wdata,
    input  logic                 bk_rsp_valid,
    input  logic [DATA_W-1:0]    bk_rsp_data
);
    import mcu_pkg::*;

    localparam int PW   = $clog2(N);
    localparam int N_LK = N + 1;

    typedef struct packed {
        mcu_state_e          st;
        logic [PW-1:0]       ptr;
        logic [PW-1:0]       own;
        logic                own_we;
        logic [ADDR_W-1:0]   own_addr;
        logic [DATA_W-1:0]   own_wdata;
        logic [N-1:0]        gnt;
        logic [N*DATA_W-1:0] rdata;
    } ctrl_t;

    ctrl_t q, d;

    logic [N_LK-1:0]        lk_hit;
    logic [N_LK*DATA_W-1:0] lk_data;
    logic [N-1:0]           elig;
    logic [PW-1:0]          pick;
    logic                   pick_any;
    logic                   st_wr_en;
    logic [DATA_W-1:0]      st_wr_data;
    logic [N-1:0]           own_mask;

    assign own_mask = N'(1) << q.own;

    mcu_line_store #(.N_LK(N_LK), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_wr_en),
        .wr_addr (q.own_addr),
        .wr_data (st_wr_data),
        .lk_addr ({q.own_addr, prt_addr}),
        .lk_hit  (lk_hit),
        .lk_data (lk_data)
    );

    always_comb begin
        elig = prt_req & ~q.gnt;
        if (q.st != ST_IDLE) elig = elig & ~prt_we & lk_hit[N-1:0] & ~own_mask;
    end

    mcu_rr_pick #(.N(N), .PW(PW)) arb_i (
        .req  (elig),
        .ptr  (q.ptr),
        .pick (pick),
        .any  (pick_any)
    );

    always_comb begin
        d          = q;
        d.gnt      = '0;
        st_wr_en   = 1'b0;
        st_wr_data = q.own_we ? q.own_wdata : bk_rsp_data;

        if (pick_any) begin
            d.ptr = (int'(pick) == N - 1) ? '0 : pick + PW'(1);
            if (q.st == ST_IDLE && (prt_we[pick] || !lk_hit[pick])) begin
                d.st        = ST_BK_REQ;
                d.own       = pick;
                d.own_we    = prt_we[pick];
                d.own_addr  = prt_addr[int'(pick)*ADDR_W +: ADDR_W];
                d.own_wdata = prt_wdata[int'(pick)*DATA_W +: DATA_W];
            end else begin
                d.gnt[pick] = 1'b1;
                d.rdata[int'(pick)*DATA_W +: DATA_W] = lk_data[int'(pick)*DATA_W +: DATA_W];
            end
        end

        case (q.st)
            ST_BK_REQ:  if (bk_ready) d.st = ST_BK_WAIT;
            ST_BK_WAIT: if (bk_rsp_valid) begin
                d.st         = ST_IDLE;
                d.gnt[q.own] = 1'b1;
                st_wr_en     = !q.own_we || lk_hit[N];
                if (!q.own_we) d.rdata[int'(q.own)*DATA_W +: DATA_W] = bk_rsp_data;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.ptr       <= '0;
            q.own       <= '0;
            q.own_we    <= 1'b0;
            q.own_addr  <= '0;
            q.own_wdata <= '0;
            q.gnt       <= '0;
            q.rdata     <= '0;
        end else begin
            q <= d;
        end
    end

    assign prt_gnt   = q.gnt;
    assign prt_rdata = q.rdata;
    assign bk_valid  = (q.st == ST_BK_REQ);
    assign bk_we     = q.own_we;
    assign bk_addr   = q.own_addr;
    assign bk_wdata  = q.own_wdata;

    p_gnt_had_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((prt_gnt & ~$past(prt_req)) == '0));
    p_gnt_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((prt_gnt & $past(prt_gnt)) == '0));
    p_grant_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(prt_gnt) <= 2));
    p_bk_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_valid && !bk_ready) |=> (bk_valid && $stable(bk_addr) && $stable(bk_we)));
endmodule

// File: tb/mcu_shared_ctrl_tb_top.sv
module mcu_shared_ctrl_tb_top;
    localparam int N = 8;
    localparam int AW = 24;
    localparam int DW = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [N-1:0]    req = '0, we = '0, gnt;
    logic [N*AW-1:0] addr = '0;
    logic [N*DW-1:0] wdata = '0, rdata;
    logic bk_valid, bk_ready = 1'b0, bk_we, bk_rsp_valid = 1'b0;
    logic [AW-1:0] bk_addr;
    logic [DW-1:0] bk_wdata, bk_rsp_data = '0;

    mcu_shared_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .prt_req(req), .prt_we(we), .prt_addr(addr),
        .prt_wdata(wdata), .prt_gnt(gnt), .prt_rdata(rdata), .bk_valid(bk_valid),
        .bk_ready(bk_ready), .bk_we(bk_we), .bk_addr(bk_addr), .bk_wdata(bk_wdata),
        .bk_rsp_valid(bk_rsp_valid), .bk_rsp_data(bk_rsp_data)
    );

    int tests = 0, fails = 0;
    int rdy_dly = 3, rsp_lat = 5;
    int bk_cnt = 0;
    logic [AW-1:0] last_addr;
    logic          last_we;
    logic [DW-1:0] last_wdata;
    logic [DW-1:0] bmem [int];

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {8{8'h5A, a}};
    endfunction

    task automatic check(input bit ok, input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // backing memory model with variable accept delay and response latency
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && bk_valid) begin
                repeat (rdy_dly) @(negedge clk);
                last_addr = bk_addr; last_we = bk_we; last_wdata = bk_wdata;
                bk_ready = 1'b1;
                @(negedge clk);
                bk_ready = 1'b0;
                bk_cnt++;
                if (last_we) bmem[int'(last_addr)] = last_wdata;
                repeat (rsp_lat - 1) @(negedge clk);
                bk_rsp_data = bmem.exists(int'(last_addr)) ? bmem[int'(last_addr)] : pat(last_addr);
                bk_rsp_valid = 1'b1;
                @(negedge clk);
                bk_rsp_valid = 1'b0;
            end
        end
    end

    task automatic access(input int p, input bit w, input logic [AW-1:0] a, input logic [DW-1:0] dat,
                          output logic [DW-1:0] r, output int cyc, output logic [N-1:0] gv);
        req[p] = 1'b1; we[p] = w; addr[p*AW +: AW] = a; wdata[p*DW +: DW] = dat;
        cyc = 0;
        do begin @(negedge clk); cyc++; end while (!gnt[p] && cyc < 2000);
        r = rdata[p*DW +: DW];
        gv = gnt;
        req[p] = 1'b0; we[p] = 1'b0;
    endtask

    localparam logic [AW-1:0] A_ADDR = 24'h000010;
    localparam logic [AW-1:0] C_ADDR = 24'h000123;
    localparam logic [AW-1:0] D_ADDR = 24'h000020;
    localparam logic [AW-1:0] E_ADDR = 24'h000207;
    localparam logic [DW-1:0] X_DAT  = {8{32'hCAFE0001}};
    localparam logic [DW-1:0] Y_DAT  = {8{32'hBEEF0002}};

    task automatic t_reset();
        check(gnt == '0, "R1 gnt after reset", DW'(gnt), '0);
        check(bk_valid == 1'b0, "R1 backing idle after reset", DW'(bk_valid), '0);
    endtask

    task automatic t_first_miss();
        logic [DW-1:0] r; int c; logic [N-1:0] g; int b0;
        b0 = bk_cnt;
        access(0, 1'b0, A_ADDR, '0, r, c, g);
        check(bk_cnt == b0 + 1, "R1 first read goes to backing", DW'(bk_cnt - b0), 1);
        check(last_addr == A_ADDR && last_we == 1'b0, "R4 backing read address", DW'(last_addr), DW'(A_ADDR));
        check(r == pat(A_ADDR), "R4 miss data from response", r, pat(A_ADDR));
    endtask

    task automatic t_hit();
        logic [DW-1:0] r; int c; logic [N-1:0] g; int b0;
        b0 = bk_cnt;
        access(3, 1'b0, A_ADDR, '0, r, c, g);
        check(c == 1 && bk_cnt == b0, "R3 hit latency one cycle, no backing", DW'(c), 1);
        check(r == pat(A_ADDR), "R3 hit data", r, pat(A_ADDR));
        check(g == 8'h08, "R9 grant only to requester", DW'(g), DW'(8'h08));
    endtask

    task automatic t_round_robin();
        logic [DW-1:0] r1, r2, r5, r6; int c1, c2, c5, c6; logic [N-1:0] g1, g2, g5, g6;
        fork
            access(1, 1'b0, A_ADDR, '0, r1, c1, g1);
            access(2, 1'b0, A_ADDR, '0, r2, c2, g2);
            access(5, 1'b0, A_ADDR, '0, r5, c5, g5);
            access(6, 1'b0, A_ADDR, '0, r6, c6, g6);
        join
        // last accepted was port 3, so the order is 5, 6, 1, 2
        check(c5 == 1 && c6 == 2, "R2 order after pointer", DW'({c5[7:0], c6[7:0]}), DW'(16'h0102));
        check(c1 == 3 && c2 == 4, "R2 wrap to low ports", DW'({c1[7:0], c2[7:0]}), DW'(16'h0304));
    endtask

    task automatic t_write_hit();
        logic [DW-1:0] r; int c; logic [N-1:0] g; int b0;
        access(2, 1'b1, A_ADDR, X_DAT, r, c, g);
        check(last_we == 1'b1 && last_addr == A_ADDR && last_wdata == X_DAT, "R5 write through", last_wdata, X_DAT);
        check(c > rsp_lat, "R5 write waits for backing", DW'(c), DW'(rsp_lat + 1));
        b0 = bk_cnt;
        access(7, 1'b0, A_ADDR, '0, r, c, g);
        check(r == X_DAT && c == 1 && bk_cnt == b0, "R6 cached line updated", r, X_DAT);
    endtask

    task automatic t_write_miss();
        logic [DW-1:0] r; int c; logic [N-1:0] g; int b0;
        access(4, 1'b1, C_ADDR, Y_DAT, r, c, g);
        b0 = bk_cnt;
        access(4, 1'b0, C_ADDR, '0, r, c, g);
        check(bk_cnt == b0 + 1, "R6 write did not allocate", DW'(bk_cnt - b0), 1);
        check(r == Y_DAT, "R5 backing holds written word", r, Y_DAT);
    endtask

    task automatic t_evict();
        logic [DW-1:0] r; int c; logic [N-1:0] g; int b0;
        b0 = bk_cnt;
        access(1, 1'b0, D_ADDR, '0, r, c, g);
        check(bk_cnt == b0 + 1 && r == pat(D_ADDR), "R7 same index other tag misses", r, pat(D_ADDR));
        access(1, 1'b0, A_ADDR, '0, r, c, g);
        check(bk_cnt == b0 + 2, "R7 evicted line misses again", DW'(bk_cnt - b0), 2);
        check(r == X_DAT, "R7 refill data", r, X_DAT);
    endtask

    task automatic t_hit_under_miss();
        logic [DW-1:0] r4, r6; int c4, c6; logic [N-1:0] g4, g6; bit miss_done;
        miss_done = 1'b0;
        rdy_dly = 2; rsp_lat = 30;
        fork
            begin access(4, 1'b0, E_ADDR, '0, r4, c4, g4); miss_done = 1'b1; end
            begin
                repeat (3) @(negedge clk);
                access(6, 1'b0, C_ADDR, '0, r6, c6, g6);
                check(c6 == 1 && !miss_done, "R8 hit served during pending miss", DW'(c6), 1);
                check(r6 == Y_DAT, "R8 hit data during miss", r6, Y_DAT);
            end
        join
        check(r4 == pat(E_ADDR), "R4 slow miss data", r4, pat(E_ADDR));
        rdy_dly = 3; rsp_lat = 5;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_miss();
        t_hit();
        t_round_robin();
        t_write_hit();
        t_write_miss();
        t_evict();
        t_hit_under_miss();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule